// File: doc/BRIEF.md
# Adder-Subtracter with Comparison Flags

This block adds or subtracts two two's complement operands of a parameterised width and classifies the outcome. When the mode input asks for subtraction, the second operand goes through a dedicated complementor, which inverts every bit and then increments. A per-bit two-way selector then feeds either the plain or the complemented operand into a ripple chain of full adders. The carry-in of that chain is fixed at zero.

The bit width of the sum, the carry out of the top stage and four flags are captured in output registers on each rising clock edge. The flags are a sign indication, an all-zero indication, a strictly-positive indication and a not-equal indication. In subtraction mode the flags compare the first operand with the second, and the sign flag is taken straight from the result's top bit. No saturation is applied and no signed-overflow correction is made. A synchronous active-high reset puts the outputs into the state of a zero result.

Top module: `arith_cmp_unit`

## Requirements
- R1: With `sub_mode` = 0, `sum_q` equals (`op_a` + `op_b`) modulo 2^W one clock edge after the operands are presented.
- R2: With `sub_mode` = 1, `sum_q` equals (`op_a` + ((~`op_b` + 1) modulo 2^W)) modulo 2^W one clock edge after the operands are presented.
- R3: `carry_q` equals bit W of the unsigned W+1-bit sum of `op_a` and the selected W-bit operand, with a carry-in of zero. As a result, subtracting zero gives `carry_q` = 0.
- R4: Complementing the most negative value (only bit W-1 set) returns that same value. Subtracting it therefore gives the same `sum_q` and `carry_q` as adding it.
- R5: `neg_q` equals bit W-1 of `sum_q`.
- R6: `zero_q` is 1 exactly when every bit of `sum_q` is 0.
- R7: `pos_q` is 1 exactly when `neg_q` and `zero_q` are both 0, so exactly one of `neg_q`, `zero_q` and `pos_q` is high in every cycle.
- R8: `ne_q` is always the inverse of `zero_q`.
- R9: While `rst` is high at a rising edge, the outputs become `sum_q` = 0, `carry_q` = 0, `zero_q` = 1, and `neg_q` = `pos_q` = `ne_q` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | W | First operand (minuend in subtraction) |
| op_b | input | W | Second operand (subtrahend in subtraction) |
| sub_mode | input | 1 | 0 selects addition, 1 selects subtraction |
| sum_q | output | W | Registered result |
| carry_q | output | 1 | Registered carry out of the most significant stage |
| neg_q | output | 1 | Registered sign flag of the result |
| zero_q | output | 1 | Registered all-zero flag of the result |
| pos_q | output | 1 | Registered strictly-positive flag |
| ne_q | output | 1 | Registered not-equal flag |

## Verification
A 4-bit copy is swept over every operand pair in both modes. This separates a fault in the complementor's increment chain from a fault in the main adder's carry chain, because the two only interact when the subtrahend has a long run of low zeros. An 8-bit copy is driven with the corner values 0, 1, -1, the largest positive and the most negative value in every pairing, and then with random pairs. The pairs with a zero subtrahend expose a carry-in trick, since such a trick would raise the carry where this design must not. Subtracting the most negative value shows that the complementor wraps onto itself. Equal operands, opposite-sign operands and wrapping sums test that exactly one of the three exclusive flags is high and that the not-equal output tracks it.

// File: rtl/arith_cmp_pkg.sv
package arith_cmp_pkg;

  typedef enum logic {
    MODE_ADD = 1'b0,
    MODE_SUB = 1'b1
  } arith_mode_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic pos;
    logic ne;
  } cmp_flags_t;

  localparam cmp_flags_t FLAGS_OF_ZERO = '{neg: 1'b0, zero: 1'b1, pos: 1'b0, ne: 1'b0};

endpackage

// File: rtl/twos_negator.sv
module twos_negator #(
  parameter int W = 8
) (
  input  logic [W-1:0] val,
  output logic [W-1:0] neg_val
);
  logic [W-1:0] inv;
  logic [W-1:0] inc_c;

  assign inv      = ~val;
  assign inc_c[0] = 1'b1;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_inc
      assign neg_val[i] = inv[i] ^ inc_c[i];
      if (i < W - 1) begin : g_carry
        assign inc_c[i+1] = inv[i] & inc_c[i];
      end
    end
  endgenerate
endmodule

// File: rtl/ripple_adder.sv
module ripple_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s,
  output logic         cout
);
  logic [W:0] c;

  assign c[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_fa
      logic p;
      assign p      = x[i] ^ y[i];
      assign s[i]   = p ^ c[i];
      assign c[i+1] = (x[i] & y[i]) | (p & c[i]);
    end
  endgenerate

  assign cout = c[W];
endmodule

// File: rtl/cmp_flag_gen.sv
module cmp_flag_gen
  import arith_cmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] res,
  output cmp_flags_t   flags
);
  logic is_neg;
  logic is_zero;

  assign is_neg  = res[W-1];
  assign is_zero = ~(|res);

  always_comb begin
    flags.neg  = is_neg;
    flags.zero = is_zero;
    flags.pos  = ~is_neg & ~is_zero;
    flags.ne   = ~is_zero;
  end
endmodule

// File: rtl/arith_cmp_unit.sv
module arith_cmp_unit
  import arith_cmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         sub_mode,
  output logic [W-1:0] sum_q,
  output logic         carry_q,
  output logic         neg_q,
  output logic         zero_q,
  output logic         pos_q,
  output logic         ne_q
);
  arith_mode_e  mode;
  logic [W-1:0] b_neg;
  logic [W-1:0] b_sel;
  logic [W-1:0] sum_d;
  logic         carry_d;
  cmp_flags_t   flags_d;
  cmp_flags_t   flags_q;

  assign mode = arith_mode_e'(sub_mode);

  twos_negator #(.W(W)) u_neg (
    .val     (op_b),
    .neg_val (b_neg)
  );

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_sel
      assign b_sel[i] = (mode == MODE_SUB) ? b_neg[i] : op_b[i];
    end
  endgenerate

  ripple_adder #(.W(W)) u_add (
    .x    (op_a),
    .y    (b_sel),
    .s    (sum_d),
    .cout (carry_d)
  );

  cmp_flag_gen #(.W(W)) u_flags (
    .res   (sum_d),
    .flags (flags_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= '0;
      carry_q <= 1'b0;
      flags_q <= FLAGS_OF_ZERO;
    end else begin
      sum_q   <= sum_d;
      carry_q <= carry_d;
      flags_q <= flags_d;
    end
  end

  assign neg_q  = flags_q.neg;
  assign zero_q = flags_q.zero;
  assign pos_q  = flags_q.pos;
  assign ne_q   = flags_q.ne;
endmodule

// File: rtl/arith_cmp_unit_chk.sv
module arith_cmp_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         sub_mode,
  input logic [W-1:0] sum_q,
  input logic         carry_q,
  input logic         neg_q,
  input logic         zero_q,
  input logic         pos_q,
  input logic         ne_q
);
  // R7
  flag_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({neg_q, zero_q, pos_q}) == 1);

  // R5
  sign_bit_chk: assert property (@(posedge clk) disable iff (rst)
    neg_q == sum_q[W-1]);

  // R6
  zero_result_chk: assert property (@(posedge clk) disable iff (rst)
    zero_q == (sum_q == '0));

  // R8
  not_equal_chk: assert property (@(posedge clk) disable iff (rst)
    ne_q != zero_q);

  // R3
  sub_zero_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (sub_mode && op_b == '0) |=> (!carry_q && sum_q == $past(op_a)));

  // R1
  add_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!sub_mode && op_b == '0) |=> (!carry_q && sum_q == $past(op_a)));

  // R2
  self_sub_chk: assert property (@(posedge clk) disable iff (rst)
    (sub_mode && op_a == op_b) |=> zero_q);

  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (sum_q == '0 && !carry_q && zero_q && !neg_q && !pos_q && !ne_q));
endmodule

bind arith_cmp_unit arith_cmp_unit_chk #(.W(W)) u_chk (.*);

// File: tb/arith_cmp_unit_tb.sv
module arith_cmp_unit_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [3:0] a4 = '0, b4 = '0;
  logic       m4 = 1'b0;
  logic [3:0] s4;
  logic       c4, n4, z4, p4, e4;

  logic [7:0] a8 = '0, b8 = '0;
  logic       m8 = 1'b0;
  logic [7:0] s8;
  logic       c8, n8, z8, p8, e8;

  arith_cmp_unit #(.W(4)) u_dut (
    .clk(clk), .rst(rst), .op_a(a4), .op_b(b4), .sub_mode(m4),
    .sum_q(s4), .carry_q(c4), .neg_q(n4), .zero_q(z4), .pos_q(p4), .ne_q(e4)
  );

  arith_cmp_unit #(.W(8)) u_dut_w8 (
    .clk(clk), .rst(rst), .op_a(a8), .op_b(b8), .sub_mode(m8),
    .sum_q(s8), .carry_q(c8), .neg_q(n8), .zero_q(z8), .pos_q(p8), .ne_q(e8)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one vector into the chosen width copy and compare after one edge.
  task automatic run_vec(input int w, input int a, input int b, input bit m);
    int mask, nb, opnd, full, es, ec, en, ez, ep;
    int rs, rc, rn, rz, rp, re;
    string arith;
    mask = (1 << w) - 1;
    nb   = ((~b) + 1) & mask;
    opnd = m ? nb : (b & mask);
    full = (a & mask) + opnd;
    es   = full & mask;
    ec   = (full >> w) & 1;
    en   = (es >> (w - 1)) & 1;
    ez   = (es == 0) ? 1 : 0;
    ep   = (en == 0 && ez == 0) ? 1 : 0;
    if (w == 4) begin
      a4 = a[3:0]; b4 = b[3:0]; m4 = m;
    end else begin
      a8 = a[7:0]; b8 = b[7:0]; m8 = m;
    end
    @(posedge clk);
    @(negedge clk);
    if (w == 4) begin
      rs = int'(s4); rc = int'(c4); rn = int'(n4); rz = int'(z4); rp = int'(p4); re = int'(e4);
    end else begin
      rs = int'(s8); rc = int'(c8); rn = int'(n8); rz = int'(z8); rp = int'(p8); re = int'(e8);
    end
    arith = m ? "R2" : "R1";
    // R4 is covered when m is set and b equals the most negative value
    if (m && b == (1 << (w - 1))) arith = "R4";
    chk(arith, "sum", rs, es);
    chk("R3", "carry", rc, ec);
    chk("R5", "neg", rn, en);
    chk("R6", "zero", rz, ez);
    chk("R7", "pos", rp, ep);
    chk("R8", "ne", re, 1 - ez);
  endtask

  initial begin
    int corner[5];
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state on both copies
    chk("R9", "w4 sum", int'(s4), 0);
    chk("R9", "w4 carry", int'(c4), 0);
    chk("R9", "w4 flags", int'({n4, z4, p4, e4}), 4'b0100);
    chk("R9", "w8 sum", int'(s8), 0);
    chk("R9", "w8 carry", int'(c8), 0);
    chk("R9", "w8 flags", int'({n8, z8, p8, e8}), 4'b0100);
    rst = 1'b0;

    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run_vec(4, a, b, bit'(m));

    corner[0] = 0; corner[1] = 1; corner[2] = 255; corner[3] = 127; corner[4] = 128;
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          run_vec(8, corner[i], corner[j], bit'(m));

    for (int k = 0; k < 300; k++)
      run_vec(8, int'($urandom_range(255)), int'($urandom_range(255)), bit'($urandom_range(1)));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule